// File: doc/BRIEF.md
# Deflection Router Port Allocator

This block is the allocation and switching stage of a router in a two-dimensional mesh that uses deflection routing. Each cycle it receives up to four flits on four internal channels. Each flit carries a valid bit, a destination X/Y coordinate and a payload. The block maps those flits one-to-one onto the North, South, East and West output ports. It does this through two stages of 2x2 pass/swap switches instead of a full crossbar.

Each switch arbitrates between its two flits. It sends the winner toward an output that brings it closer to its destination, and the loser takes the remaining output. One valid flit per cycle is chosen at random and marked silver. The silver flit wins every arbitration it enters, so it always reaches a productive port if it has one. Ties between two ordinary valid flits are broken by pseudo-random bits from a registered 16-bit shift-register generator. This generator is the only state in the block.

The outputs give each port's flit (its destination and payload unchanged), a valid bit, a productive flag and a silver marker. A router around this block uses the productive flag to tell whether a flit was deflected.

Top module: `dfl_port_alloc`

## Requirements
- R1: Every valid input flit appears on exactly one output port with its destination and payload unchanged. The number of valid outputs equals the number of valid inputs.
- R2: out_prod[p] is 1 exactly when port p holds a valid flit and p lowers its distance. The port indices are North=0 (dst_y > self_y), South=1 (dst_y < self_y), East=2 (dst_x > self_x) and West=3 (dst_x < self_x).
- R3: out_silver has exactly one bit set when any input is valid, and none otherwise. The set bit marks a valid output port.
- R4: The silver flit always lands on a productive port when its destination differs from the router's own coordinate.
- R5: With no valid inputs, all of out_valid, out_prod and out_silver are zero, including while reset is held.
- R6: A flit whose destination equals the router's coordinate is still delivered to some port, with its productive flag at 0.
- R7: The first-stage switches pair channels 0/1 and 2/3. A second-stage switch then owns either the N/S axis or the E/W axis. When each pair holds one flit that wants only the Y axis and one that wants only the X axis, every valid flit gets a productive port. This also covers a lone valid flit with any productive direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the random-bit generator |
| rst | input | 1 | Synchronous reset, loads the generator seed |
| self_x | input | COORD_W | Router X coordinate |
| self_y | input | COORD_W | Router Y coordinate |
| in_valid | input | 4 | Per-channel flit present |
| in_dst_x | input | 4*COORD_W | Per-channel destination X, channel i at bits i*COORD_W |
| in_dst_y | input | 4*COORD_W | Per-channel destination Y |
| in_payload | input | 4*PAYLOAD_W | Per-channel payload |
| out_valid | output | 4 | Per-port flit present (N,S,E,W = 0..3) |
| out_prod | output | 4 | Per-port productive flag |
| out_silver | output | 4 | Per-port silver marker |
| out_dst_x | output | 4*COORD_W | Per-port destination X |
| out_dst_y | output | 4*COORD_W | Per-port destination Y |
| out_payload | output | 4*PAYLOAD_W | Per-port payload |

## Verification
Lone flits are driven on every channel toward every direction, and also toward the router itself. These separate wrong steering inside a switch from wrong productive flags and from a lost or duplicated flit. Full-load vectors with one Y-only and one X-only flit per first-stage pair show whether the axis grouping and the pass/swap rule give all four flits productive ports. All four flits wanting North forces real contention and deflections. Long runs of random vectors then check that the permutation, the single silver marker and silver productivity hold under every mix of tie-breaks.

// File: rtl/dfl_pkg.sv
`timescale 1ns/1ps
package dfl_pkg;
    parameter int COORD_W   = 3;
    parameter int PAYLOAD_W = 12;
    parameter int NUM_PORTS = 4;
    parameter int LFSR_W    = 16;
    parameter int RND_W     = 6;

    localparam int PORT_N = 0;
    localparam int PORT_S = 1;
    localparam int PORT_E = 2;
    localparam int PORT_W = 3;

    typedef struct packed {
        logic                 valid;
        logic                 silver;
        logic [COORD_W-1:0]   dx;
        logic [COORD_W-1:0]   dy;
        logic [PAYLOAD_W-1:0] payload;
    } flit_t;

    // 1 when output direction 'port' brings (dx,dy) closer from (sx,sy)
    function automatic logic dir_ok(input int port,
                                    input logic [COORD_W-1:0] dx,
                                    input logic [COORD_W-1:0] dy,
                                    input logic [COORD_W-1:0] sx,
                                    input logic [COORD_W-1:0] sy);
        logic r;
        case (port)
            PORT_N:  r = (dy > sy);
            PORT_S:  r = (dy < sy);
            PORT_E:  r = (dx > sx);
            default: r = (dx < sx);
        endcase
        return r;
    endfunction
endpackage

// File: rtl/dfl_lfsr.sv
`timescale 1ns/1ps
module dfl_lfsr #(
    parameter int          W     = 16,
    parameter int          OUT_W = 6,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    output logic [OUT_W-1:0] rnd
);
    logic [W-1:0] state_q;
    logic         fb;

    // taps for x^16 + x^14 + x^13 + x^11 + 1 (maximal length)
    assign fb = state_q[W-1] ^ state_q[W-3] ^ state_q[W-4] ^ state_q[W-6];

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEED;
        else     state_q <= {state_q[W-2:0], fb};
    end

    assign rnd = state_q[OUT_W-1:0] ^ state_q[W-1:W-OUT_W];

    // a maximal sequence seeded non-zero never collapses to zero
    p_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);
endmodule

// File: rtl/dfl_silver_pick.sv
`timescale 1ns/1ps
module dfl_silver_pick #(
    parameter int N   = 4,
    localparam int SW = $clog2(N)
) (
    input  logic [N-1:0]  valid,
    input  logic [SW-1:0] start,
    output logic [N-1:0]  onehot
);
    // rotating scan: first valid channel at or after 'start'
    always_comb begin
        logic found;
        int   idx;
        onehot = '0;
        found  = 1'b0;
        for (int k = 0; k < N; k++) begin
            idx = (int'(start) + k) % N;
            if (!found && valid[idx]) begin
                onehot[idx] = 1'b1;
                found       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dfl_switch2.sv
`timescale 1ns/1ps
module dfl_switch2 import dfl_pkg::*; (
    input  flit_t in_a,
    input  flit_t in_b,
    input  logic  a_p0,
    input  logic  a_p1,
    input  logic  b_p0,
    input  logic  b_p1,
    input  logic  rnd,
    output flit_t out0,
    output flit_t out1
);
    logic a_wins;
    logic swap;

    always_comb begin
        // silver beats all; a valid flit beats an empty slot; else coin flip
        if (in_a.silver)      a_wins = 1'b1;
        else if (in_b.silver) a_wins = 1'b0;
        else if (!in_b.valid) a_wins = in_a.valid;
        else if (!in_a.valid) a_wins = 1'b0;
        else                  a_wins = rnd;

        // pass unless only the opposite output helps the winner
        if (a_wins) swap = !a_p0 && a_p1;
        else        swap = b_p0 && !b_p1;

        out0 = swap ? in_b : in_a;
        out1 = swap ? in_a : in_b;
    end
endmodule

// File: rtl/dfl_port_alloc.sv
`timescale 1ns/1ps
module dfl_port_alloc import dfl_pkg::*; (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [COORD_W-1:0]             self_x,
    input  logic [COORD_W-1:0]             self_y,
    input  logic [NUM_PORTS-1:0]           in_valid,
    input  logic [NUM_PORTS*COORD_W-1:0]   in_dst_x,
    input  logic [NUM_PORTS*COORD_W-1:0]   in_dst_y,
    input  logic [NUM_PORTS*PAYLOAD_W-1:0] in_payload,
    output logic [NUM_PORTS-1:0]           out_valid,
    output logic [NUM_PORTS-1:0]           out_prod,
    output logic [NUM_PORTS-1:0]           out_silver,
    output logic [NUM_PORTS*COORD_W-1:0]   out_dst_x,
    output logic [NUM_PORTS*COORD_W-1:0]   out_dst_y,
    output logic [NUM_PORTS*PAYLOAD_W-1:0] out_payload
);
    localparam int HALF = NUM_PORTS / 2;

    logic [RND_W-1:0]     rnd;
    logic [NUM_PORTS-1:0] silver_oh;
    logic [NUM_PORTS-1:0] want_x;
    logic [NUM_PORTS-1:0] want_y;
    flit_t                fin [NUM_PORTS];
    flit_t                mid [NUM_PORTS];
    flit_t                fo  [NUM_PORTS];

    dfl_lfsr #(.W(LFSR_W), .OUT_W(RND_W)) u_lfsr (
        .clk (clk),
        .rst (rst),
        .rnd (rnd)
    );

    dfl_silver_pick #(.N(NUM_PORTS)) u_silver (
        .valid  (in_valid),
        .start  (rnd[1:0]),
        .onehot (silver_oh)
    );

    // channel unpacking
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_in
        assign fin[i] = '{valid:   in_valid[i],
                          silver:  silver_oh[i],
                          dx:      in_dst_x[i*COORD_W +: COORD_W],
                          dy:      in_dst_y[i*COORD_W +: COORD_W],
                          payload: in_payload[i*PAYLOAD_W +: PAYLOAD_W]};
        assign want_y[i] = (fin[i].dy != self_y);
        assign want_x[i] = (fin[i].dx != self_x);
    end

    // stage 1: output 0 feeds the N/S switch, output 1 the E/W switch
    for (genvar g = 0; g < HALF; g++) begin : g_s1
        dfl_switch2 u_sw (
            .in_a (fin[2*g]),
            .in_b (fin[2*g+1]),
            .a_p0 (want_y[2*g]),
            .a_p1 (want_x[2*g]),
            .b_p0 (want_y[2*g+1]),
            .b_p1 (want_x[2*g+1]),
            .rnd  (rnd[2+g]),
            .out0 (mid[2*g]),
            .out1 (mid[2*g+1])
        );
    end

    // stage 2: j=0 owns N/S (ports 0,1); j=1 owns E/W (ports 2,3)
    for (genvar j = 0; j < HALF; j++) begin : g_s2
        logic ap0, ap1, bp0, bp1;
        assign ap0 = dir_ok(2*j,   mid[j].dx,      mid[j].dy,      self_x, self_y);
        assign ap1 = dir_ok(2*j+1, mid[j].dx,      mid[j].dy,      self_x, self_y);
        assign bp0 = dir_ok(2*j,   mid[j+HALF].dx, mid[j+HALF].dy, self_x, self_y);
        assign bp1 = dir_ok(2*j+1, mid[j+HALF].dx, mid[j+HALF].dy, self_x, self_y);
        dfl_switch2 u_sw (
            .in_a (mid[j]),
            .in_b (mid[j+HALF]),
            .a_p0 (ap0),
            .a_p1 (ap1),
            .b_p0 (bp0),
            .b_p1 (bp1),
            .rnd  (rnd[4+j]),
            .out0 (fo[2*j]),
            .out1 (fo[2*j+1])
        );
    end

    // port packing
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_out
        assign out_valid[p]  = fo[p].valid;
        assign out_silver[p] = fo[p].silver;
        assign out_prod[p]   = fo[p].valid &&
                               dir_ok(p, fo[p].dx, fo[p].dy, self_x, self_y);
        assign out_dst_x[p*COORD_W +: COORD_W]       = fo[p].dx;
        assign out_dst_y[p*COORD_W +: COORD_W]       = fo[p].dy;
        assign out_payload[p*PAYLOAD_W +: PAYLOAD_W] = fo[p].payload;
    end

    // silver flit has somewhere productive to go
    logic silver_wants;
    assign silver_wants = |(silver_oh & in_valid & (want_x | want_y));

    p_count_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(out_valid) == $countones(in_valid));

    p_single_silver_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_silver) && ((|out_silver) == (|in_valid)));

    p_silver_prod_r4: assert property (@(posedge clk) disable iff (rst)
        silver_wants |-> |(out_silver & out_prod));

    p_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid == '0) |-> (out_valid == '0 && out_prod == '0));
endmodule

// File: tb/dfl_port_alloc_bench.sv
`timescale 1ns/1ps
module dfl_port_alloc_bench;
    localparam int CW = dfl_pkg::COORD_W;
    localparam int PW = dfl_pkg::PAYLOAD_W;

    typedef struct packed {
        logic [3:0]      v;
        logic [4*CW-1:0] x;
        logic [4*CW-1:0] y;
        logic [4*PW-1:0] pl;
        logic [CW-1:0]   sx;
        logic [CW-1:0]   sy;
        logic            all_prod;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [CW-1:0]   self_x = '0, self_y = '0;
    logic [3:0]      in_valid = '0;
    logic [4*CW-1:0] in_dst_x = '0, in_dst_y = '0;
    logic [4*PW-1:0] in_payload = '0;
    logic [3:0]      out_valid, out_prod, out_silver;
    logic [4*CW-1:0] out_dst_x, out_dst_y;
    logic [4*PW-1:0] out_payload;

    int   checks = 0;
    int   errors = 0;
    int   uniq   = 1;
    bit   done   = 0;
    exp_t q[$];

    always #5 clk = ~clk;

    dfl_port_alloc u_dfl_port_alloc (
        .clk(clk), .rst(rst), .self_x(self_x), .self_y(self_y),
        .in_valid(in_valid), .in_dst_x(in_dst_x), .in_dst_y(in_dst_y),
        .in_payload(in_payload), .out_valid(out_valid), .out_prod(out_prod),
        .out_silver(out_silver), .out_dst_x(out_dst_x), .out_dst_y(out_dst_y),
        .out_payload(out_payload)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit helps(input int p, input int dx, input int dy,
                                 input int sx, input int sy);
        if (p == 0) return dy > sy;
        if (p == 1) return dy < sy;
        if (p == 2) return dx > sx;
        return dx < sx;
    endfunction

    task automatic add(inout exp_t e, input int ch, input int x, input int y);
        e.v[ch] = 1'b1;
        e.x[ch*CW +: CW] = x[CW-1:0];
        e.y[ch*CW +: CW] = y[CW-1:0];
        e.pl[ch*PW +: PW] = uniq[PW-1:0];
        uniq++;
    endtask

    task automatic drive(input exp_t e);
        @(posedge clk);
        #1;
        self_x = e.sx; self_y = e.sy;
        in_valid = e.v; in_dst_x = e.x; in_dst_y = e.y; in_payload = e.pl;
        q.push_back(e);
    endtask

    task automatic verify(input exp_t e);
        int nin, nout, hits, ox, oy, sx, sy;
        sx = int'(e.sx); sy = int'(e.sy);
        nin = $countones(e.v); nout = $countones(out_valid);
        check(nout == nin, "R1", "valid count", nout, nin);
        for (int i = 0; i < 4; i++) begin
            if (e.v[i]) begin
                hits = 0;
                for (int p = 0; p < 4; p++)
                    if (out_valid[p] && out_payload[p*PW +: PW] == e.pl[i*PW +: PW]
                        && out_dst_x[p*CW +: CW] == e.x[i*CW +: CW]
                        && out_dst_y[p*CW +: CW] == e.y[i*CW +: CW]) hits++;
                check(hits == 1, "R1", "copies of flit", hits, 1);
            end
        end
        for (int p = 0; p < 4; p++) begin
            bit expp;
            ox = int'(out_dst_x[p*CW +: CW]); oy = int'(out_dst_y[p*CW +: CW]);
            expp = out_valid[p] && helps(p, ox, oy, sx, sy);
            check(out_prod[p] == expp, "R2", "productive flag", int'(out_prod[p]), int'(expp));
            if (out_valid[p] && ox == sx && oy == sy)
                check(out_prod[p] == 1'b0, "R6", "flag at destination", int'(out_prod[p]), 0);
            if (out_silver[p] && (ox != sx || oy != sy))
                check(out_prod[p] == 1'b1, "R4", "silver productive", int'(out_prod[p]), 1);
            if (e.all_prod && out_valid[p])
                check(out_prod[p] == 1'b1, "R7", "all productive", int'(out_prod[p]), 1);
        end
        check($countones(out_silver) == (nin > 0 ? 1 : 0), "R3", "silver count",
              $countones(out_silver), nin > 0 ? 1 : 0);
        check((out_silver & ~out_valid) == 4'b0, "R3", "silver on empty port",
              int'(out_silver & ~out_valid), 0);
        if (nin == 0)
            check(out_valid == 4'b0 && out_prod == 4'b0 && out_silver == 4'b0,
                  "R5", "idle outputs", int'({out_valid, out_prod, out_silver}), 0);
    endtask

    // monitor: pops expectations away from the active edge
    always @(negedge clk) begin
        if (!rst && q.size() > 0) verify(q.pop_front());
    end

    initial begin
        exp_t e;
        int dxs[4] = '{3, 3, 5, 1};
        int dys[4] = '{5, 1, 3, 3};
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 4'b0 && out_prod == 4'b0 && out_silver == 4'b0,
              "R5", "outputs in reset", int'({out_valid, out_prod, out_silver}), 0);
        @(posedge clk); #1 rst = 1'b0;

        e = '0; e.sx = 3; e.sy = 3;
        repeat (3) drive(e);

        // R7 lone flits toward each direction, and diagonals
        for (int ch = 0; ch < 4; ch++) begin
            for (int d = 0; d < 4; d++) begin
                e = '0; e.sx = 3; e.sy = 3; e.all_prod = 1;
                add(e, ch, dxs[d], dys[d]); drive(e);
            end
            e = '0; e.sx = 3; e.sy = 3; e.all_prod = 1;
            add(e, ch, 6, 0); drive(e);
        end

        // R6 lone flit addressed to this router
        for (int ch = 0; ch < 4; ch++) begin
            e = '0; e.sx = 3; e.sy = 3;
            add(e, ch, 3, 3); drive(e);
        end

        // R7 full load with one Y-only and one X-only flit per pair
        for (int r = 0; r < 20; r++) begin
            e = '0; e.sx = 4; e.sy = 4; e.all_prod = 1;
            add(e, 0, 4, 6); add(e, 1, 6, 4); add(e, 2, 4, 1); add(e, 3, 1, 4);
            drive(e);
            e = '0; e.sx = 4; e.sy = 4; e.all_prod = 1;
            add(e, 0, 6, 4); add(e, 1, 4, 6); add(e, 2, 1, 4); add(e, 3, 4, 1);
            drive(e);
            e = '0; e.sx = 4; e.sy = 4; e.all_prod = 1;
            add(e, 0, 4, 7); add(e, 1, 0, 4); add(e, 2, 4, 0); add(e, 3, 7, 4);
            drive(e);
        end

        // contention: everything wants North
        for (int r = 0; r < 20; r++) begin
            e = '0; e.sx = 2; e.sy = 2;
            for (int ch = 0; ch < 4; ch++) add(e, ch, 2, 7);
            drive(e);
        end

        // random mixes
        for (int r = 0; r < 600; r++) begin
            int vm;
            e = '0;
            e.sx = CW'($urandom_range(0, 7)); e.sy = CW'($urandom_range(0, 7));
            vm = $urandom_range(0, 15);
            for (int ch = 0; ch < 4; ch++)
                if (vm[ch]) add(e, ch, $urandom_range(0, 7), $urandom_range(0, 7));
            if (uniq > 4000) uniq = 1;
            drive(e);
        end

        e = '0; drive(e);
        repeat (3) @(posedge clk);
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule